// File: doc/BRIEF.md
# Dual-Clock FIFO With Programmable Flags

This block is a first-in first-out buffer, 36 bits wide and 1024 words deep, placed between a write port (the A side) and a read port (the B side) that run on separate clocks. The two clocks may be unrelated or may be the same net. Each port moves one word on a rising edge of its own clock when its active-low select is low and its enable is high. On the write side the block reports whether space is available (`in_rdy`) and whether the free space has fallen to a programmable level (`alm_full_n`). On the read side it reports whether a word is available (`out_rdy`) and whether the stored count has fallen to a programmable level (`alm_empty_n`). The two level values arrive as static inputs from a separate offset-programming block.

Each side has a small state machine. The write side has `WS_RESET`, `WS_OPEN` and `WS_FULL`. The transitions are: release (`WS_RESET`→`WS_OPEN` on the first write-clock edge after reset), fill (`WS_OPEN`→`WS_FULL` when the next occupancy equals the depth) and drain (`WS_FULL`→`WS_OPEN` when it drops below the depth). The read side has `RS_RESET`, `RS_DRY` and `RS_WET`. Its transitions are: release (`RS_RESET`→`RS_DRY`), arrive (`RS_DRY`→`RS_WET` when the next count is non-zero) and exhaust (`RS_WET`→`RS_DRY` when it reaches zero). Binary pointers cross between the domains as Gray code through two flip-flops.

Top module: `dcfifo_top`

## Requirements
- R1: A word is written only on a rising `wr_clk` edge where `wr_sel_n` is 0, `wr_en` is 1 and `in_rdy` is 1. A word is read only on a rising `rd_clk` edge where `rd_sel_n` is 0, `rd_en` is 1 and `out_rdy` is 1. Any other combination moves nothing.
- R2: Words leave in the order they were written. `rd_data` is a register that takes the read word on the `rd_clk` edge that performs the read, and it holds its value otherwise.
- R3: `in_rdy` is 0 exactly when 1024 words are stored, as seen in the write domain. Writes attempted while it is 0 are discarded.
- R4: `out_rdy` is 1 when at least one word is stored, as seen in the read domain. A read attempted while it is 0 leaves `rd_data` and the FIFO contents unchanged.
- R5: While `rst_n` is 0, the FIFO empties, `in_rdy` is 0, `out_rdy` is 0, `alm_empty_n` is 0 and `alm_full_n` is 1. `in_rdy` becomes 1 on the first `wr_clk` edge after release.
- R6: `alm_empty_n` is 0 when the stored count, seen in the read domain, is less than or equal to `ae_level`. Otherwise it is 1.
- R7: `alm_full_n` is 0 when the free count (1024 minus stored), seen in the write domain, is less than or equal to `af_level`. Otherwise it is 1.
- R8: The read-side flags change only on `rd_clk` and the write-side flags only on `wr_clk`. With both clocks tied together, a write into an empty FIFO on edge k raises `out_rdy` on edge k+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| wr_sel_n | input | 1 | Write port select, active low |
| wr_en | input | 1 | Write port enable, active high |
| wr_data | input | 36 | Word to store |
| in_rdy | output | 1 | Space available; 0 means full |
| alm_full_n | output | 1 | Active-low almost-full flag |
| af_level | input | 10 | Almost-full free-space threshold |
| rd_sel_n | input | 1 | Read port select, active low |
| rd_en | input | 1 | Read port enable, active high |
| rd_data | output | 36 | Last word read |
| out_rdy | output | 1 | Word available |
| alm_empty_n | output | 1 | Active-low almost-empty flag |
| ae_level | input | 10 | Almost-empty stored-count threshold |

## Verification
A pointer that steps wrongly would show up on the very next read as a word out of order or repeated on `rd_data`. A wrong state on either side shows up as a flag that disagrees with the reference occupancy once both sides settle, which is within three edges of the other clock. A full or empty state that is never entered makes the bench see more reads than writes, or extra accepted writes, by the end of the fill and drain sequence. The threshold comparisons are checked at occupancies exactly at the programmed level and one past it.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;
    typedef enum logic [1:0] {
        WS_RESET = 2'd0,
        WS_OPEN  = 2'd1,
        WS_FULL  = 2'd2
    } wr_state_e;

    typedef enum logic [1:0] {
        RS_RESET = 2'd0,
        RS_DRY   = 2'd1,
        RS_WET   = 2'd2
    } rd_state_e;
endpackage

// File: rtl/dcfifo_sync.sv
module dcfifo_sync #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/dcfifo_wr_ctl.sv
module dcfifo_wr_ctl
    import dcfifo_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_n,
    input  logic          en,
    input  logic [AW-1:0] af_level,
    input  logic [AW:0]   rgray_s,
    output logic          fire,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wgray,
    output logic          in_rdy,
    output logic          alm_full_n
);
    localparam logic [AW:0] DEPTH_V = {1'b1, {AW{1'b0}}};

    wr_state_e   state, st_nx;
    logic [AW:0] wbin, wbin_nx, rbin_s, used_nx, free_nx;
    logic        full_nx;

    always_comb begin
        rbin_s[AW] = rgray_s[AW];
        for (int i = AW - 1; i >= 0; i--) begin
            rbin_s[i] = rbin_s[i+1] ^ rgray_s[i];
        end
    end

    assign fire    = !sel_n && en && (state == WS_OPEN);
    assign wbin_nx = wbin + {{AW{1'b0}}, fire};
    assign used_nx = wbin_nx - rbin_s;
    assign free_nx = DEPTH_V - used_nx;
    assign full_nx = (used_nx == DEPTH_V);
    assign waddr   = wbin[AW-1:0];

    always_comb begin
        st_nx = state;
        unique case (state)
            WS_RESET: st_nx = WS_OPEN;
            WS_OPEN:  st_nx = full_nx ? WS_FULL : WS_OPEN;
            WS_FULL:  st_nx = full_nx ? WS_FULL : WS_OPEN;
            default:  st_nx = WS_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= WS_RESET;
            wbin  <= '0;
            wgray <= '0;
        end else begin
            state <= st_nx;
            wbin  <= wbin_nx;
            wgray <= wbin_nx ^ (wbin_nx >> 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alm_full_n <= 1'b1;
        end else begin
            alm_full_n <= !(free_nx <= {1'b0, af_level});
        end
    end

    assign in_rdy = (state == WS_OPEN);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wbin - rbin_s) <= DEPTH_V); // R3
    AST_NO_WRITE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WS_FULL) |=> $stable(wbin)); // R3
    AST_AF_AT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WS_FULL) |-> !alm_full_n); // R7
    AST_WGRAY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wgray ^ $past(wgray)) <= 1); // R8
    AST_OPEN_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WS_RESET) |=> in_rdy); // R5
endmodule

// File: rtl/dcfifo_rd_ctl.sv
module dcfifo_rd_ctl
    import dcfifo_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_n,
    input  logic          en,
    input  logic [AW-1:0] ae_level,
    input  logic [AW:0]   wgray_s,
    output logic          fire,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rgray,
    output logic          out_rdy,
    output logic          alm_empty_n
);
    localparam logic [AW:0] DEPTH_V = {1'b1, {AW{1'b0}}};

    rd_state_e   state, st_nx;
    logic [AW:0] rbin, rbin_nx, wbin_s, count_nx;
    logic        empty_nx;

    always_comb begin
        wbin_s[AW] = wgray_s[AW];
        for (int i = AW - 1; i >= 0; i--) begin
            wbin_s[i] = wbin_s[i+1] ^ wgray_s[i];
        end
    end

    assign fire     = !sel_n && en && (state == RS_WET);
    assign rbin_nx  = rbin + {{AW{1'b0}}, fire};
    assign count_nx = wbin_s - rbin_nx;
    assign empty_nx = (count_nx == '0);
    assign raddr    = rbin[AW-1:0];

    always_comb begin
        st_nx = state;
        unique case (state)
            RS_RESET: st_nx = RS_DRY;
            RS_DRY:   st_nx = empty_nx ? RS_DRY : RS_WET;
            RS_WET:   st_nx = empty_nx ? RS_DRY : RS_WET;
            default:  st_nx = RS_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RS_RESET;
            rbin  <= '0;
            rgray <= '0;
        end else begin
            state <= st_nx;
            rbin  <= rbin_nx;
            rgray <= rbin_nx ^ (rbin_nx >> 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alm_empty_n <= 1'b0;
        end else begin
            alm_empty_n <= !(count_nx <= {1'b0, ae_level});
        end
    end

    assign out_rdy = (state == RS_WET);

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wbin_s - rbin) <= DEPTH_V); // R4
    AST_AE_WHEN_DRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state != RS_WET) |-> !alm_empty_n); // R6
    AST_RGRAY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rgray ^ $past(rgray)) <= 1); // R8
endmodule

// File: rtl/dcfifo_top.sv
module dcfifo_top #(
    parameter int DW = 36,
    parameter int AW = 10
) (
    input  logic          wr_clk,
    input  logic          rd_clk,
    input  logic          rst_n,
    input  logic          wr_sel_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic          in_rdy,
    output logic          alm_full_n,
    input  logic [AW-1:0] af_level,
    input  logic          rd_sel_n,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          out_rdy,
    output logic          alm_empty_n,
    input  logic [AW-1:0] ae_level
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic          wfire, rfire;
    logic [AW-1:0] waddr, raddr;
    logic [AW:0]   wgray, rgray, wgray_s, rgray_s;

    dcfifo_wr_ctl #(.AW(AW)) u_wr (
        .clk(wr_clk), .rst_n(rst_n), .sel_n(wr_sel_n), .en(wr_en),
        .af_level(af_level), .rgray_s(rgray_s), .fire(wfire),
        .waddr(waddr), .wgray(wgray), .in_rdy(in_rdy),
        .alm_full_n(alm_full_n)
    );

    dcfifo_rd_ctl #(.AW(AW)) u_rd (
        .clk(rd_clk), .rst_n(rst_n), .sel_n(rd_sel_n), .en(rd_en),
        .ae_level(ae_level), .wgray_s(wgray_s), .fire(rfire),
        .raddr(raddr), .rgray(rgray), .out_rdy(out_rdy),
        .alm_empty_n(alm_empty_n)
    );

    dcfifo_sync #(.W(AW + 1)) u_w2r (
        .clk(rd_clk), .rst_n(rst_n), .d(wgray), .q(wgray_s)
    );

    dcfifo_sync #(.W(AW + 1)) u_r2w (
        .clk(wr_clk), .rst_n(rst_n), .d(rgray), .q(rgray_s)
    );

    always_ff @(posedge wr_clk) begin
        if (wfire) begin
            mem[waddr] <= wr_data;
        end
    end

    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rfire) begin
            rd_data <= mem[raddr];
        end
    end

    AST_READ_HOLD_EMPTY: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (!rd_sel_n && rd_en && !out_rdy) |=> $stable(rd_data)); // R4
    AST_READ_NEEDS_SELECT: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (rd_sel_n || !rd_en) |=> $stable(rd_data)); // R1
endmodule

// File: tb/dcfifo_tb.sv
`timescale 1ns/1ps
module dcfifo_top_tb_top;
    localparam int DEPTH = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_sel_n = 1'b1, wr_en = 1'b0, rd_sel_n = 1'b1, rd_en = 1'b0;
    logic [35:0] wr_data = '0;
    logic [9:0]  af_level = 10'd3, ae_level = 10'd4;
    logic        in_rdy, alm_full_n, out_rdy, alm_empty_n;
    logic [35:0] rd_data;

    int unsigned n_chk = 0, n_fail = 0, n_reads = 0;
    logic [35:0] q[$];

    always #5 clk = ~clk;

    dcfifo_top dut_i (
        .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n),
        .wr_sel_n(wr_sel_n), .wr_en(wr_en), .wr_data(wr_data),
        .in_rdy(in_rdy), .alm_full_n(alm_full_n), .af_level(af_level),
        .rd_sel_n(rd_sel_n), .rd_en(rd_en), .rd_data(rd_data),
        .out_rdy(out_rdy), .alm_empty_n(alm_empty_n), .ae_level(ae_level)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit exp_ae(input int cnt);
        return !(cnt <= int'(ae_level));
    endfunction

    function automatic bit exp_af(input int cnt);
        return !((DEPTH - cnt) <= int'(af_level));
    endfunction

    // one clock, inputs driven at the falling edge, results checked at the next falling edge
    task automatic step(input logic ws_n, input logic we, input logic rs_n, input logic re);
        logic [63:0] t;
        logic [35:0] e;
        bit w_ok, r_ok;
        t = {$urandom(), $urandom()};
        wr_data = t[35:0];
        wr_sel_n = ws_n; wr_en = we; rd_sel_n = rs_n; rd_en = re;
        w_ok = !ws_n && we && in_rdy;
        r_ok = !rs_n && re && out_rdy;
        @(posedge clk);
        if (w_ok) q.push_back(t[35:0]);
        @(negedge clk);
        if (r_ok) begin
            e = q.pop_front();
            n_reads++;
            chk(rd_data == e, "R2 read order", rd_data, e);
        end
        wr_sel_n = 1'b1; wr_en = 1'b0; rd_sel_n = 1'b1; rd_en = 1'b0;
    endtask

    task automatic settle();
        for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic check_flags(input string tag);
        int c;
        c = q.size();
        chk(out_rdy == (c > 0), {tag, " R4 out_rdy"}, out_rdy, c > 0);
        chk(in_rdy == (c < DEPTH), {tag, " R3 in_rdy"}, in_rdy, c < DEPTH);
        chk(alm_empty_n == exp_ae(c), {tag, " R6 alm_empty_n"}, alm_empty_n, exp_ae(c));
        chk(alm_full_n == exp_af(c), {tag, " R7 alm_full_n"}, alm_full_n, exp_af(c));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic [35:0] held;
        int unsigned seed;
        seed = $urandom(32'd20240611);
        // R5: reset values
        repeat (3) @(negedge clk);
        chk(in_rdy == 1'b0, "R5 in_rdy in reset", in_rdy, 0);
        chk(out_rdy == 1'b0, "R5 out_rdy in reset", out_rdy, 0);
        chk(alm_empty_n == 1'b0, "R5 alm_empty_n in reset", alm_empty_n, 0);
        chk(alm_full_n == 1'b1, "R5 alm_full_n in reset", alm_full_n, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_rdy == 1'b1, "R5 in_rdy after release", in_rdy, 1);
        settle();
        check_flags("R5 empty");

        // R8: write on edge k, out_rdy rises after edge k+3
        step(1'b0, 1'b1, 1'b1, 1'b0);
        chk(out_rdy == 1'b0, "R8 latency k", out_rdy, 0);
        step(1'b1, 1'b0, 1'b1, 1'b0);
        chk(out_rdy == 1'b0, "R8 latency k+1", out_rdy, 0);
        step(1'b1, 1'b0, 1'b1, 1'b0);
        chk(out_rdy == 1'b0, "R8 latency k+2", out_rdy, 0);
        step(1'b1, 1'b0, 1'b1, 1'b0);
        chk(out_rdy == 1'b1, "R8 latency k+3", out_rdy, 1);
        step(1'b1, 1'b0, 1'b0, 1'b1);
        settle();
        check_flags("R2 drained");

        // R1: partial qualifiers move nothing
        step(1'b1, 1'b1, 1'b1, 1'b0);
        step(1'b0, 1'b0, 1'b1, 1'b0);
        settle();
        chk(out_rdy == 1'b0, "R1 unqualified write", out_rdy, 0);

        // R4: read of empty FIFO leaves rd_data unchanged
        held = rd_data;
        step(1'b1, 1'b0, 1'b0, 1'b1);
        step(1'b1, 1'b0, 1'b0, 1'b1);
        chk(rd_data == held, "R4 empty read holds", rd_data, held);

        // R6 threshold boundary
        for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b1, 1'b0);
        settle();
        check_flags("R6 at level");
        step(1'b0, 1'b1, 1'b1, 1'b0);
        settle();
        check_flags("R6 above level");
        // R1: read with select high leaves the data in place
        step(1'b1, 1'b0, 1'b1, 1'b1);
        settle();
        check_flags("R1 unselected read");

        // R7 threshold boundary, then R3 full
        while (q.size() < DEPTH - 4) step(1'b0, 1'b1, 1'b1, 1'b0);
        settle();
        check_flags("R7 one above level");
        step(1'b0, 1'b1, 1'b1, 1'b0);
        settle();
        check_flags("R7 at level");
        while (q.size() < DEPTH) step(1'b0, 1'b1, 1'b1, 1'b0);
        settle();
        check_flags("R3 full");
        for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 1'b1, 1'b0);
        chk(q.size() == DEPTH, "R3 writes while full", q.size(), DEPTH);
        n_reads = 0;
        while (out_rdy) step(1'b1, 1'b0, 1'b0, 1'b1);
        settle();
        chk(n_reads == DEPTH, "R3 drained count", n_reads, DEPTH);
        check_flags("R4 empty again");

        // random traffic with periodic settled checks
        for (int blk = 0; blk < 20; blk++) begin
            ae_level = 10'($urandom_range(0, 40));
            af_level = 10'($urandom_range(0, 40));
            for (int i = 0; i < 200; i++) begin
                step(($urandom_range(0, 3) == 0), ($urandom_range(0, 4) != 0),
                     ($urandom_range(0, 3) == 0), ($urandom_range(0, 2) != 0));
            end
            settle();
            check_flags("R6 R7 random");
        end

        // R5: reset with data inside
        for (int i = 0; i < 10; i++) step(1'b0, 1'b1, 1'b1, 1'b0);
        settle();
        rst_n = 1'b0;
        @(negedge clk);
        chk(in_rdy == 1'b0, "R5 in_rdy mid-run reset", in_rdy, 0);
        chk(out_rdy == 1'b0, "R5 out_rdy mid-run reset", out_rdy, 0);
        q.delete();
        @(negedge clk);
        rst_n = 1'b1;
        settle();
        check_flags("R5 after mid-run reset");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule